// File: doc/BRIEF.md
# Command/Address Parity Checker

This block watches a DRAM-style command and address bus and verifies an even-parity bit sent alongside each command. A command is only examined on a rising clock edge where the active-low select line is low. The examined set is:

- the activate flag;
- the three command lines that double as address bits;
- the row/column address;
- the bank and bank-group fields;
- when the block is built for stacked dies, three stack-select bits.

Select itself is not part of the parity. Address bits that the chosen density or organisation leaves unused are cleared through a static mask before the check.

A mismatch produces a one-clock error pulse in the cycle after the failing command. The first failing command word, with the mask already applied, is captured into a hold register. It stays there until the controller asserts a clear. A separate enable, driven from outside by mode-register logic, turns checking off completely.

Top module: `ca_parity_check`

## Requirements
- R1: With checking enabled and select low, an error is flagged when the parity input XOR all covered bits is 1 (even parity). When that XOR is 0, no error is flagged.
- R2: The covered command word places its fields at these bit positions:

  | Bits | Field |
  |------|-------|
  | 17:0 | masked address |
  | 20:18 | shared command lines |
  | 21 | activate flag |
  | 23:22 | bank |
  | 25:24 | bank group |
  | 28:26 | stack select |

  Inverting any single covered bit of a correctly protected command raises an error.
- R3: With the stack parameter on (default), the stack-select bits are covered and captured. With it off, they are ignored and read as zero in the captured word.
- R4: While select is high, no check is made and no error is raised, whatever the parity.
- R5: Address bits set in the static unused mask are treated as zero. Toggling them neither raises an error nor appears in the captured word.
- R6: While the enable is low, no error is raised and the hold register is not loaded.
- R7: The error output goes high exactly one clock after a failing command and lasts one cycle per failing command. Back-to-back failing commands give back-to-back pulses.
- R8: The first failing command word is loaded into the hold register. Later failures leave it unchanged until a clear.
- R9: A clear sets the hold register to zero. If a failure arrives on the same edge as a clear, that failure's word is loaded instead.
- R10: The active-low asynchronous reset clears the error output, the hold register and the captured-state flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock, rising edge active |
| rst_n | input | 1 | asynchronous reset, active low |
| cmd_act | input | 1 | activate flag |
| cmd_lines | input | 3 | command lines shared with address |
| cmd_addr | input | ADDR_W (18) | address bits |
| cmd_bank | input | 2 | bank field |
| cmd_group | input | 2 | bank-group field |
| cmd_stack | input | STACK_W (3) | stack-select bits |
| sel_n | input | 1 | command select, active low |
| par_in | input | 1 | parity bit sent with the command |
| par_enable | input | 1 | checking enable |
| addr_unused | input | ADDR_W (18) | static mask of unused address bits |
| hold_clear | input | 1 | empties the hold register |
| err_pulse | output | 1 | one-cycle parity error pulse |
| hold_word | output | ADDR_W+STACK_W+8 (29) | captured failing command word |

## Verification
The bench applies several kinds of input:

- Random commands carrying correct parity, which must never flag.
- Commands with the parity bit inverted, which must always flag.
- A walk that inverts each of the 29 word positions in turn. This separates covered bits from masked address bits and shows each field landing in its documented slot of the captured word.
- Failing commands sent with select high and with the enable low, which separate the gating conditions from the parity itself.
- Failure sequences mixed with clears, which tell first-capture retention apart from overwrite and show clear priority against a coincident failure.

A long random mix of all of these is compared against a reference model held in the bench.

// File: rtl/ca_parity_check.sv
module ca_parity_check #(
  parameter int ADDR_W   = 18,
  parameter int STACK_W  = 3,
  parameter bit STACK_EN = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_act,
  input  logic [2:0]                  cmd_lines,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [1:0]                  cmd_bank,
  input  logic [1:0]                  cmd_group,
  input  logic [STACK_W-1:0]          cmd_stack,
  input  logic                        sel_n,
  input  logic                        par_in,
  input  logic                        par_enable,
  input  logic [ADDR_W-1:0]           addr_unused,
  input  logic                        hold_clear,
  output logic                        err_pulse,
  output logic [ADDR_W+STACK_W+7:0]   hold_word
);
  localparam int WORD_W = ADDR_W + STACK_W + 8;

  logic [STACK_W-1:0] stack_eff;
  logic [WORD_W-1:0]  word;
  logic               bad;
  logic               held;

  generate
    if (STACK_EN) begin : g_stack
      assign stack_eff = cmd_stack;
    end else begin : g_nostack
      assign stack_eff = '0;
    end
  endgenerate

  assign word = {stack_eff, cmd_group, cmd_bank, cmd_act, cmd_lines,
                 cmd_addr & ~addr_unused};
  assign bad  = par_enable & ~sel_n & ((^word) ^ par_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      hold_word <= '0;
      held      <= 1'b0;
    end else begin
      err_pulse <= bad;
      if (bad && (!held || hold_clear)) begin
        hold_word <= word;
        held      <= 1'b1;
      end else if (hold_clear) begin
        hold_word <= '0;
        held      <= 1'b0;
      end
    end
  end
endmodule

module ca_parity_check_chk #(
  parameter int ADDR_W   = 18,
  parameter int STACK_W  = 3,
  parameter bit STACK_EN = 1'b1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sel_n,
  input logic                      par_enable,
  input logic                      hold_clear,
  input logic [ADDR_W-1:0]         addr_unused,
  input logic                      err_pulse,
  input logic [ADDR_W+STACK_W+7:0] hold_word
);
  // R4
  no_check_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !err_pulse);

  // R6
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_enable |=> !err_pulse);

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(!sel_n && par_enable));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_pulse && !$past(hold_clear)) |-> $stable(hold_word));

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_clear) && !err_pulse) |-> (hold_word == '0));

  // R5
  masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_word[ADDR_W-1:0] & addr_unused) == '0);

  generate
    if (!STACK_EN) begin : g_nostack_chk
      // R3
      stack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_word[ADDR_W+STACK_W+7:ADDR_W+8] == '0);
    end
  endgenerate
endmodule

bind ca_parity_check ca_parity_check_chk #(
  .ADDR_W(ADDR_W), .STACK_W(STACK_W), .STACK_EN(STACK_EN)
) chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .par_enable(par_enable),
  .hold_clear(hold_clear), .addr_unused(addr_unused),
  .err_pulse(err_pulse), .hold_word(hold_word)
);

// File: tb/ca_parity_check_test.sv
module ca_parity_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_act = 1'b0;
  logic [2:0]  cmd_lines = '0;
  logic [17:0] cmd_addr = '0;
  logic [1:0]  cmd_bank = '0;
  logic [1:0]  cmd_group = '0;
  logic [2:0]  cmd_stack = '0;
  logic        sel_n = 1'b1;
  logic        par_in = 1'b0;
  logic        par_enable = 1'b1;
  logic [17:0] addr_unused = 18'h22000;
  logic        hold_clear = 1'b0;
  logic        err_pulse;
  logic [28:0] hold_word;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        err;
    logic [28:0] hold;
    string       req;
  } exp_t;

  exp_t        q[$];
  logic [28:0] m_hold = '0;
  logic        m_held = 1'b0;

  always #5 clk = ~clk;

  ca_parity_check uut (
    .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_lines(cmd_lines),
    .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .cmd_group(cmd_group),
    .cmd_stack(cmd_stack), .sel_n(sel_n), .par_in(par_in),
    .par_enable(par_enable), .addr_unused(addr_unused),
    .hold_clear(hold_clear), .err_pulse(err_pulse), .hold_word(hold_word)
  );

  function automatic logic [28:0] cov(input logic [28:0] w);
    return w & ~{11'b0, addr_unused};
  endfunction

  task automatic check(input logic [28:0] act, input logic [28:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [28:0] w, input logic par, input logic sn,
                      input logic en, input logic clr, input string req);
    exp_t e;
    logic bad;
    @(negedge clk);
    cmd_addr = w[17:0]; cmd_lines = w[20:18]; cmd_act = w[21];
    cmd_bank = w[23:22]; cmd_group = w[25:24]; cmd_stack = w[28:26];
    par_in = par; sel_n = sn; par_enable = en; hold_clear = clr;
    bad = en & ~sn & ((^cov(w)) ^ par);
    if (bad && (!m_held || clr)) begin
      m_hold = cov(w); m_held = 1'b1;
    end else if (clr) begin
      m_hold = '0; m_held = 1'b0;
    end
    e.err = bad; e.hold = m_hold; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input string req);
    send(29'h0, 1'b0, 1'b1, 1'b1, 1'b0, req);
  endtask

  task automatic drain;
    @(posedge clk); #2;
    @(posedge clk); #2;
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({28'b0, err_pulse}, {28'b0, e.err}, e.req, "err_pulse");
      check(hold_word, e.hold, e.req, "hold_word");
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [28:0] w;
    repeat (3) @(posedge clk);
    #2;
    check({28'b0, err_pulse}, 29'h0, "R10", "reset err_pulse");
    check(hold_word, 29'h0, "R10", "reset hold_word");
    @(negedge clk); rst_n = 1'b1;

    // R1 correct parity never flags
    for (int i = 0; i < 20; i++) begin
      w = 29'($urandom);
      send(w, ^cov(w), 1'b0, 1'b1, 1'b0, "R1");
    end
    // R1 R7 R8 inverted parity, back-to-back, first capture held
    w = 29'h0ABC_1234;
    send(w, ~(^cov(w)), 1'b0, 1'b1, 1'b0, "R1");
    send(29'h1555_5555, ~(^cov(29'h1555_5555)), 1'b0, 1'b1, 1'b0, "R7");
    idle("R7");
    send(29'h0F0F_0F0F, ~(^cov(29'h0F0F_0F0F)), 1'b0, 1'b1, 1'b0, "R8");
    idle("R8");
    // R9 clear alone, then clear with coincident failure
    send(29'h0, 1'b0, 1'b1, 1'b1, 1'b1, "R9");
    idle("R9");
    send(29'h0123_4567, ~(^cov(29'h0123_4567)), 1'b0, 1'b1, 1'b0, "R9");
    send(29'h1FED_CBA9, ~(^cov(29'h1FED_CBA9)), 1'b0, 1'b1, 1'b1, "R9");
    idle("R9");
    // R2 R3 R5 single-bit walk over the whole word
    for (int b = 0; b < 29; b++) begin
      string r;
      w = 29'($urandom);
      r = (b < 18 && addr_unused[b]) ? "R5" : (b >= 26 ? "R3" : "R2");
      send(w ^ (29'h1 << b), ^cov(w), 1'b0, 1'b1, 1'b1, r);
    end
    send(29'h0, 1'b0, 1'b1, 1'b1, 1'b1, "R9");
    // R5 masked bits alone with zero parity
    send(29'h0002_2000, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    // R4 deselected bad parity
    send(29'h0000_0001, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
    send(29'h1000_0000, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
    // R6 disabled bad parity
    send(29'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    send(29'h0400_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    // R1 random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rnd;
      logic [28:0] rw;
      rnd = $urandom;
      rw = 29'($urandom);
      send(rw, (^cov(rw)) ^ (rnd[1:0] == 2'b00), rnd[4:2] == 3'b000,
           rnd[7:5] != 3'b000, rnd[11:8] == 4'h0, "R1");
    end
    // R10 reset mid-run after a capture
    send(29'h0000_0007, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    idle("R8");
    drain();
    @(negedge clk); rst_n = 1'b0;
    #2;
    check({28'b0, err_pulse}, 29'h0, "R10", "async reset err_pulse");
    check(hold_word, 29'h0, "R10", "async reset hold_word");
    m_hold = '0; m_held = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    send(29'h0000_0003, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
    idle("R10");
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule